// File: doc/BRIEF.md
# Serially Programmed Dual Frequency Divider

This block divides two count-enable streams, one from a reference source and one from a VCO path, by ratios that a controller sets over a three-wire serial link. The link has a bit clock, a data line and a load strobe. Each rising bit clock shifts one data bit into a 17-bit shift word, most significant bit first. A rising load strobe then copies the 16 payload bits into one of two latches: the reference setting or the VCO setting. The last bit shifted in chooses the latch.

The reference path normally divides by four times a 14-bit count. In that mode a fixed divide-by-four prescale runs ahead of the programmable counter. A direct-mode bit in the reference setting removes the prescale, so the ratio becomes the 14-bit count itself. The VCO path divides by a 16-bit ratio. Each path produces a one-cycle pulse every time its counter reloads. The two test outputs copy these pulses. An outputs-off bit in the reference setting forces both test outputs low.

All serial inputs are sampled by the system clock. A divider input event is a system clock cycle in which the matching enable input is high.

Top module: `fdiv_top`

## Requirements
- R1: On each rising edge of `ser_clk`, `ser_dat` is shifted into a 17-bit word, most significant bit first. The 16 bits shifted first form the payload, with the first bit being payload bit 15. The 17th bit, shifted last, is the select bit.
- R2: A rising edge of `ser_le` with select = 1 loads the reference setting, and the VCO ratio is left unchanged. The reference setting uses payload bit 15 as outputs-off, bit 14 as direct mode, and bits 13:0 as the count.
- R3: A rising edge of `ser_le` with select = 0 loads payload bits 15:0 as the VCO ratio, and the reference setting is left unchanged.
- R4: A loaded reference count below 7 is stored as 7. A loaded VCO ratio below 28 is stored as 28.
- R5: With direct mode = 0, `ref_pulse` repeats every 4 × count reference input events.
- R6: With direct mode = 1, `ref_pulse` repeats every count reference input events.
- R7: `vco_pulse` repeats every VCO-ratio VCO input events, for any ratio from 28 to 65535.
- R8: Each output pulse lasts one cycle. It is asserted only in the cycle after an input event that reaches terminal count.
- R9: A newly loaded ratio takes effect only at the next reload. The count already in progress finishes with the old ratio.
- R10: While outputs-off = 1, `fr_out` and `fn_out` stay low, and the divider pulses continue. While outputs-off = 0, `fr_out` equals `ref_pulse` and `fn_out` equals `vco_pulse`.
- R11: After synchronous reset, both ratios are 28 (reference count 7, direct mode 0), outputs-off is 0, and no pulse is asserted.
- R12: Shifting bits without a rising edge of `ser_le` changes neither stored setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial bit clock, sampled by clk |
| ser_dat | input | 1 | Serial data, taken on a rising ser_clk |
| ser_le | input | 1 | Load strobe, rising edge transfers the word |
| ref_ce | input | 1 | Reference input event |
| vco_ce | input | 1 | VCO input event |
| ref_pulse | output | 1 | One-cycle reference divider pulse |
| vco_pulse | output | 1 | One-cycle VCO divider pulse |
| fr_out | output | 1 | Reference test output, gated by outputs-off |
| fn_out | output | 1 | VCO test output, gated by outputs-off |

## Verification
The assertions assume the serial lines are already synchronous to `clk`. The bench therefore holds each data bit and each strobe level steady for at least one whole clock period around every sampled edge. The one-cycle pulse properties rely on the stored minimum ratios, so they hold for any pattern of enable inputs. The bench runs both dividers with the enable inputs held high. The one exception is the reload-timing case, where the VCO enable is paused mid-count so the remaining count is known exactly.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
    localparam int PAY_W = 16;
    localparam int SR_W  = PAY_W + 1;
    localparam int REF_W = 14;
    localparam int N_W   = 16;

    typedef struct packed {
        logic             out_off;
        logic             direct;
        logic [REF_W-1:0] cnt;
    } ref_word_t;
endpackage

// File: rtl/fdiv_serial.sv
module fdiv_serial
    import fdiv_pkg::*;
#(
    parameter int REF_MIN = 7,
    parameter int N_MIN   = 28
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_clk,
    input  logic             ser_dat,
    input  logic             ser_le,
    output logic [REF_W-1:0] ref_cnt,
    output logic             ref_direct,
    output logic             out_off,
    output logic [N_W-1:0]   n_ratio
);
    typedef struct packed {
        logic            sclk_prev;
        logic            le_prev;
        logic [SR_W-1:0] shreg;
        ref_word_t       ref_set;
        logic [N_W-1:0]  n_set;
    } state_t;

    state_t    st_d, st_q;
    ref_word_t word_w;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = ser_clk;
        st_d.le_prev   = ser_le;
        word_w         = ref_word_t'(st_q.shreg[SR_W-1:1]);
        if (ser_clk && !st_q.sclk_prev) begin
            st_d.shreg = {st_q.shreg[SR_W-2:0], ser_dat};
        end
        if (ser_le && !st_q.le_prev) begin
            if (st_q.shreg[0]) begin
                st_d.ref_set = word_w;
                if (word_w.cnt < REF_W'(REF_MIN)) begin
                    st_d.ref_set.cnt = REF_W'(REF_MIN);
                end
            end else begin
                st_d.n_set = st_q.shreg[SR_W-1:1];
                if (st_q.shreg[SR_W-1:1] < N_W'(N_MIN)) begin
                    st_d.n_set = N_W'(N_MIN);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.sclk_prev       <= 1'b0;
            st_q.le_prev         <= 1'b0;
            st_q.shreg           <= '0;
            st_q.ref_set.out_off <= 1'b0;
            st_q.ref_set.direct  <= 1'b0;
            st_q.ref_set.cnt     <= REF_W'(REF_MIN);
            st_q.n_set           <= N_W'(N_MIN);
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_cnt    = st_q.ref_set.cnt;
    assign ref_direct = st_q.ref_set.direct;
    assign out_off    = st_q.ref_set.out_off;
    assign n_ratio    = st_q.n_set;
endmodule

// File: rtl/fdiv_counter.sv
module fdiv_counter #(
    parameter int W   = 16,
    parameter int MIN = 28
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] ratio,
    output logic         pulse
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         pulse;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (tick) begin
            if (st_q.cnt <= W'(1)) begin
                st_d.cnt   = ratio;
                st_d.pulse = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt   <= W'(MIN);
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse = st_q.pulse;
endmodule

// File: rtl/fdiv_refpath.sv
module fdiv_refpath #(
    parameter int W       = 14,
    parameter int MIN     = 7,
    parameter int PRE_DIV = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ce,
    input  logic         direct,
    input  logic [W-1:0] ratio,
    output logic         pulse
);
    localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

    logic [PRE_W-1:0] pre_d, pre_q;
    logic             tick;

    always_comb begin
        pre_d = pre_q;
        if (ce) begin
            pre_d = (pre_q == PRE_LAST) ? '0 : pre_q + PRE_W'(1);
        end
        tick = ce && (direct || (pre_q == PRE_LAST));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

    fdiv_counter #(.W(W), .MIN(MIN)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .ratio (ratio),
        .pulse (pulse)
    );
endmodule

// File: rtl/fdiv_top.sv
module fdiv_top
    import fdiv_pkg::*;
#(
    parameter int REF_MIN = 7,
    parameter int N_MIN   = 28,
    parameter int PRE_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ser_clk,
    input  logic ser_dat,
    input  logic ser_le,
    input  logic ref_ce,
    input  logic vco_ce,
    output logic ref_pulse,
    output logic vco_pulse,
    output logic fr_out,
    output logic fn_out
);
    logic [REF_W-1:0] ref_cnt_w;
    logic             ref_direct_w;
    logic             out_off_w;
    logic [N_W-1:0]   n_ratio_w;

    fdiv_serial #(.REF_MIN(REF_MIN), .N_MIN(N_MIN)) u_ser (
        .clk        (clk),
        .rst        (rst),
        .ser_clk    (ser_clk),
        .ser_dat    (ser_dat),
        .ser_le     (ser_le),
        .ref_cnt    (ref_cnt_w),
        .ref_direct (ref_direct_w),
        .out_off    (out_off_w),
        .n_ratio    (n_ratio_w)
    );

    fdiv_refpath #(.W(REF_W), .MIN(REF_MIN), .PRE_DIV(PRE_DIV)) u_ref (
        .clk    (clk),
        .rst    (rst),
        .ce     (ref_ce),
        .direct (ref_direct_w),
        .ratio  (ref_cnt_w),
        .pulse  (ref_pulse)
    );

    fdiv_counter #(.W(N_W), .MIN(N_MIN)) u_vco (
        .clk   (clk),
        .rst   (rst),
        .tick  (vco_ce),
        .ratio (n_ratio_w),
        .pulse (vco_pulse)
    );

    assign fr_out = ref_pulse && !out_off_w;
    assign fn_out = vco_pulse && !out_off_w;
endmodule

// File: rtl/fdiv_checker.sv
module fdiv_checker
    import fdiv_pkg::*;
#(
    parameter int REF_MIN = 7,
    parameter int N_MIN   = 28
) (
    input logic             clk,
    input logic             rst,
    input logic             ser_le,
    input logic             ref_ce,
    input logic             vco_ce,
    input logic             ref_pulse,
    input logic             vco_pulse,
    input logic             fr_out,
    input logic             fn_out,
    input logic             out_off,
    input logic [REF_W-1:0] ref_cnt,
    input logic [N_W-1:0]   n_ratio
);
    logic le_seen;
    always_ff @(posedge clk) le_seen <= ser_le;

    AST_VCO_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) vco_pulse |=> !vco_pulse); // R8
    AST_REF_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) ref_pulse |=> !ref_pulse); // R8
    AST_VCO_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst) vco_pulse |-> $past(vco_ce)); // R8
    AST_REF_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst) ref_pulse |-> $past(ref_ce)); // R8
    AST_OUTPUTS_OFF: assert property (@(posedge clk) disable iff (rst) out_off |-> (!fr_out && !fn_out)); // R10
    AST_SETTINGS_HOLD: assert property (@(posedge clk) disable iff (rst) !(ser_le && !le_seen) |=> ($stable(n_ratio) && $stable(ref_cnt) && $stable(out_off))); // R12
    AST_FLOOR_N: assert property (@(posedge clk) disable iff (rst) n_ratio >= N_W'(N_MIN)); // R4
    AST_FLOOR_REF: assert property (@(posedge clk) disable iff (rst) ref_cnt >= REF_W'(REF_MIN)); // R4
endmodule

bind fdiv_top fdiv_checker #(.REF_MIN(REF_MIN), .N_MIN(N_MIN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ser_le    (ser_le),
    .ref_ce    (ref_ce),
    .vco_ce    (vco_ce),
    .ref_pulse (ref_pulse),
    .vco_pulse (vco_pulse),
    .fr_out    (fr_out),
    .fn_out    (fn_out),
    .out_off   (out_off_w),
    .ref_cnt   (ref_cnt_w),
    .n_ratio   (n_ratio_w)
);

// File: tb/tb_fdiv_top.sv
module tb_fdiv_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
    logic ref_ce = 1'b0, vco_ce = 1'b0;
    logic ref_pulse, vco_pulse, fr_out, fn_out;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    fdiv_top dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
        .ref_ce(ref_ce), .vco_ce(vco_ce), .ref_pulse(ref_pulse), .vco_pulse(vco_pulse),
        .fr_out(fr_out), .fn_out(fn_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic shift_word(input logic sel, input logic [15:0] w);
        logic [16:0] fr;
        fr = {w, sel};
        for (int i = 16; i >= 0; i--) begin
            @(negedge clk); ser_dat = fr[i]; ser_clk = 1'b0;
            @(negedge clk); ser_clk = 1'b1;
            @(negedge clk); ser_clk = 1'b0;
        end
    endtask

    task automatic send(input logic sel, input logic [15:0] w);
        shift_word(sel, w);
        @(negedge clk); ser_le = 1'b1;
        @(negedge clk); ser_le = 1'b0;
        @(negedge clk);
    endtask

    // returns cycles between two successive pulses of the chosen path (1 = reference)
    task automatic period(input bit use_ref, output int n);
        int guard;
        guard = 0;
        n = 0;
        @(negedge clk);
        while (!(use_ref ? ref_pulse : vco_pulse) && guard < 70000) begin
            @(negedge clk); guard++;
        end
        do begin
            @(negedge clk); n++;
        end while (!(use_ref ? ref_pulse : vco_pulse) && n < 70000);
    endtask

    task automatic settled_period(input bit use_ref, output int n);
        int tmp;
        period(use_ref, tmp);
        period(use_ref, n);
    endtask

    task automatic t_reset;
        int n;
        check(!ref_pulse && !vco_pulse && !fr_out && !fn_out, "R11", int'(ref_pulse | vco_pulse), 0);
        ref_ce = 1'b1; vco_ce = 1'b1;
        period(1'b0, n); check(n == 28, "R11 vco", n, 28);
        period(1'b1, n); check(n == 28, "R11 ref", n, 28);
    endtask

    task automatic t_reload;  // R9: in-flight count finishes with old ratio
        int n;
        rst = 1'b1; vco_ce = 1'b0; ref_ce = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); vco_ce = 1'b1;
        repeat (10) @(negedge clk);
        vco_ce = 1'b0;
        send(1'b0, 16'd40);
        vco_ce = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!vco_pulse && n < 1000);
        check(n == 18, "R9 old ratio", n, 18);
        n = 0;
        do begin @(negedge clk); n++; end while (!vco_pulse && n < 1000);
        check(n == 40, "R9 new ratio", n, 40);
        ref_ce = 1'b1;
    endtask

    task automatic t_vco;
        int n;
        send(1'b0, 16'd100);
        settled_period(1'b0, n); check(n == 100, "R7 N=100", n, 100);
        settled_period(1'b1, n); check(n == 28, "R3 ref untouched", n, 28);
        send(1'b0, 16'h0100);
        settled_period(1'b0, n); check(n == 256, "R1 msb first", n, 256);
        send(1'b0, 16'd5);
        settled_period(1'b0, n); check(n == 28, "R4 N clamp", n, 28);
        send(1'b0, 16'd300);
        settled_period(1'b0, n); check(n == 300, "R7 N=300", n, 300);
    endtask

    task automatic t_ref;
        int n;
        send(1'b1, 16'h0019);
        settled_period(1'b1, n); check(n == 100, "R5 4x25", n, 100);
        settled_period(1'b0, n); check(n == 300, "R2 N untouched", n, 300);
        send(1'b1, 16'h4032);
        settled_period(1'b1, n); check(n == 50, "R6 direct 50", n, 50);
        send(1'b1, 16'h4002);
        settled_period(1'b1, n); check(n == 7, "R4 direct clamp", n, 7);
        send(1'b1, 16'h0003);
        settled_period(1'b1, n); check(n == 28, "R4 normal clamp", n, 28);
    endtask

    task automatic t_hold;  // R12
        int n;
        shift_word(1'b1, 16'h4009);
        repeat (4) @(negedge clk);
        settled_period(1'b1, n); check(n == 28, "R12 ref held", n, 28);
        settled_period(1'b0, n); check(n == 300, "R12 N held", n, 300);
    endtask

    task automatic t_gate;  // R10
        int rp, fp, np, vp;
        send(1'b1, 16'hC007);
        rp = 0; fp = 0; np = 0; vp = 0;
        for (int i = 0; i < 700; i++) begin
            @(negedge clk);
            rp += int'(ref_pulse); fp += int'(fr_out);
            vp += int'(vco_pulse); np += int'(fn_out);
        end
        check(fp == 0 && np == 0, "R10 off", fp + np, 0);
        check(rp > 0 && vp > 0, "R10 pulses run", rp, 100);
        send(1'b1, 16'h4007);
        fp = 0; np = 0;
        for (int i = 0; i < 700; i++) begin
            @(negedge clk);
            if (fr_out != ref_pulse || fn_out != vco_pulse) np++;
            fp += int'(fr_out);
        end
        check(np == 0 && fp > 0, "R10 on", fp, 100);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_reload();
        t_vco();
        t_ref();
        t_hold();
        t_gate();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule